// File: doc/BRIEF.md
# Video Register Port I/O Latch

This block models the CPU-facing register port of a video controller that occupies the address window $2000-$3FFF. The window holds eight registers, and they repeat every eight bytes, so only the three low address bits select a register. Every access goes through one shared 8-bit I/O latch. A write puts the CPU byte into the latch, and the latch then hands that byte to the selected register one cycle later. A read first lets the selected register overwrite the latch bits it owns and then returns the whole latch. Bits that the register does not own keep whatever an earlier transaction left in them.

Three inputs stand in for the register sources. A 3-bit status source feeds offset 2. A sprite-data byte feeds offset 4. A read-buffer byte feeds the data port at offset 7, and a palette flag says whether the data address currently points into palette space. Rendering, memory timing and the side effects of a status read are outside this block. The surrounding logic takes forwarded register writes from the write port and takes read results from the latch output when the read-valid pulse is high.

Top module: `vidreg_latch_top`

## Requirements
- R1: After reset the latch reads $00, and neither read-valid nor the write strobe is high.
- R2: A write inside the window loads the written byte into all 8 latch bits at the clock edge that samples it.
- R3: One cycle after the latch loads, a write pulses `wr_stb` for one cycle. In that cycle `wr_sel` carries the register offset and `wr_data` carries the written byte.
- R4: A read of offset 0, 1, 3, 5 or 6 leaves the latch unchanged, so it returns the last byte written or read.
- R5: A read of offset 2 puts the status source into latch bits 7-5 (status bit 2 in latch bit 7) and keeps latch bits 4-0.
- R6: A read of offset 4 loads all 8 latch bits from the sprite-data input.
- R7: A read of offset 7 while the palette flag is low loads all 8 latch bits from the read-buffer input.
- R8: A read of offset 7 while the palette flag is high loads latch bits 5-0 from the read buffer and keeps latch bits 7-6.
- R9: Any address from $2000 to $3FFF selects offset address[2:0]; for example $2102 and $3F02 both select offset 2.
- R10: An idle cycle, or an access with its address outside $2000-$3FFF, changes neither the latch nor read-valid nor the write strobe.
- R11: A read inside the window raises `rd_valid` for exactly the one cycle after the edge that sampled it, and `io_latch` holds the read result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | An access is presented in this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | Write data |
| stat_flags | input | 3 | Status flags returned by offset 2 |
| spr_data | input | 8 | Sprite data returned by offset 4 |
| rbuf_data | input | 8 | Read-buffer byte returned by offset 7 |
| pal_space | input | 1 | The data address points into palette space |
| io_latch | output | 8 | Current I/O latch; this is the read data |
| rd_valid | output | 1 | A read result is on io_latch |
| wr_stb | output | 1 | A forwarded register write |
| wr_sel | output | 3 | Offset of the forwarded write |
| wr_data | output | 8 | Data of the forwarded write |

## Verification
A read is sampled at a rising edge. Its result sits on `io_latch`, with `rd_valid` high, from that edge until the next one, which makes it due one edge after the request. A write's latch value is due at that same first edge, and the write strobe carrying the forwarded byte follows one edge later. The bench drives every access at a falling edge and samples outputs only at falling edges. A monitor pops queued expected reads and forwarded writes in the half-cycle in which each one becomes due. After each idle or out-of-window access the bench also compares the latch directly against the value the bench model holds.

// File: rtl/vidreg_pkg.sv
// Package: shared register offsets and widths for the video register port.
// Assumes eight registers selected by the low three address bits.
package vidreg_pkg;

    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int STAT_W   = 3;
    localparam int PAL_OWN  = 6;

    // Register offsets inside one 8-byte mirror
    typedef enum logic [SEL_W-1:0] {
        OFS_CTRL    = 3'd0,
        OFS_MODE    = 3'd1,
        OFS_STATUS  = 3'd2,
        OFS_SPRPTR  = 3'd3,
        OFS_SPRDAT  = 3'd4,
        OFS_SCROLL  = 3'd5,
        OFS_DPTR    = 3'd6,
        OFS_DPORT   = 3'd7
    } vreg_ofs_e;

    // Per-bit ownership of one register read: which latch bits it replaces
    typedef struct packed {
        logic [DATA_W-1:0] own;
        logic [DATA_W-1:0] src;
    } rd_drive_t;

endpackage

// File: rtl/vidreg_decode.sv
// Module: window hit and mirrored register select.
// Assumes the window is a power-of-two aligned block of 2**WIN_LOG2 bytes;
// the register select is the low SEL_W address bits regardless of mirror.
module vidreg_decode #(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_LOG2 = 13,
    parameter int                SEL_W    = 3,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h2000
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [SEL_W-1:0]  sel
);
    localparam int TAG_W = ADDR_W - WIN_LOG2;
    localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:WIN_LOG2];

    // Compare the address tag above the window against the base tag
    always_comb begin
        hit = (addr[ADDR_W-1:WIN_LOG2] == BASE_TAG);
    end

    // Register select ignores every mirror bit between SEL_W and WIN_LOG2
    always_comb begin
        sel = addr[SEL_W-1:0];
    end
endmodule

// File: rtl/vidreg_merge.sv
// Module: computes the latch value after a read.
// The addressed register replaces only the bits it owns; every other bit
// keeps the current latch. Write-only offsets own no bits.
module vidreg_merge
    import vidreg_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int S_W   = SEL_W,
    parameter int ST_W  = STAT_W,
    parameter int PAL_W = PAL_OWN
) (
    input  logic [S_W-1:0]  sel,
    input  logic [ST_W-1:0] stat_flags,
    input  logic [D_W-1:0]  spr_data,
    input  logic [D_W-1:0]  rbuf_data,
    input  logic            pal_space,
    input  logic [D_W-1:0]  latch_q,
    output logic [D_W-1:0]  latch_nxt
);
    localparam int STAT_LO = D_W - ST_W;
    localparam logic [D_W-1:0] ALL_ONES  = {D_W{1'b1}};
    localparam logic [D_W-1:0] STAT_MASK = ALL_ONES << STAT_LO;
    localparam logic [D_W-1:0] PAL_MASK  = ALL_ONES >> (D_W - PAL_W);

    rd_drive_t drv;

    // Select ownership mask and source byte for the addressed register
    always_comb begin
        drv.own = '0;
        drv.src = '0;
        case (vreg_ofs_e'(sel))
            OFS_STATUS: begin
                drv.own = STAT_MASK;
                drv.src = {stat_flags, {STAT_LO{1'b0}}};
            end
            OFS_SPRDAT: begin
                drv.own = ALL_ONES;
                drv.src = spr_data;
            end
            OFS_DPORT: begin
                drv.own = pal_space ? PAL_MASK : ALL_ONES;
                drv.src = rbuf_data;
            end
            default: begin
                drv.own = '0;
                drv.src = '0;
            end
        endcase
    end

    // Per-bit merge of owned source bits over the held latch bits
    genvar b;
    generate
        for (b = 0; b < D_W; b++) begin : g_bit
            assign latch_nxt[b] = drv.own[b] ? drv.src[b] : latch_q[b];
        end
    endgenerate
endmodule

// File: rtl/vidreg_latch.sv
// Module: the shared I/O latch, the read-valid flag and the delayed
// forwarding of writes. A write is forwarded from the latch one cycle after
// the latch loads, so the target always receives the latched byte.
module vidreg_latch #(
    parameter int D_W = 8,
    parameter int S_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_en,
    input  logic [D_W-1:0] load_val,
    input  logic           rd_go,
    input  logic           wr_go,
    input  logic [S_W-1:0] wr_go_sel,
    output logic [D_W-1:0] latch_q,
    output logic           rd_valid,
    output logic           wr_stb,
    output logic [S_W-1:0] wr_sel,
    output logic [D_W-1:0] wr_data
);
    logic           pend_v;
    logic [S_W-1:0] pend_sel;

    // Latch register: loads on every accepted access, clears on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (load_en) begin
            latch_q <= load_val;
        end
    end

    // Read-valid pulse for the cycle after a read is sampled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_go;
        end
    end

    // Remember a write for one cycle so it forwards from the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_sel <= '0;
        end else begin
            pend_v   <= wr_go;
            pend_sel <= wr_go_sel;
        end
    end

    // Forward the pending write, carrying the byte now held in the latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            wr_sel  <= '0;
            wr_data <= '0;
        end else begin
            wr_stb  <= pend_v;
            wr_sel  <= pend_sel;
            wr_data <= pend_v ? latch_q : wr_data;
        end
    end
endmodule

// File: rtl/vidreg_latch_top.sv
// Module: top of the video register port. Decodes the mirrored window,
// merges register read data into the shared latch, loads writes into it,
// and forwards writes to the register file side.
// Assumes one access per cycle, qualified by bus_req.
module vidreg_latch_top
    import vidreg_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_LOG2 = 13,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'h2000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [STAT_W-1:0]    stat_flags,
    input  logic [DATA_W-1:0]    spr_data,
    input  logic [DATA_W-1:0]    rbuf_data,
    input  logic                 pal_space,
    output logic [DATA_W-1:0]    io_latch,
    output logic                 rd_valid,
    output logic                 wr_stb,
    output logic [SEL_W-1:0]     wr_sel,
    output logic [DATA_W-1:0]    wr_data
);
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] merged;
    logic              acc;
    logic [DATA_W-1:0] load_val;

    vidreg_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_LOG2 (WIN_LOG2),
        .SEL_W    (SEL_W),
        .WIN_BASE (WIN_BASE)
    ) u_decode (
        .addr (bus_addr),
        .hit  (hit),
        .sel  (sel)
    );

    vidreg_merge u_merge (
        .sel        (sel),
        .stat_flags (stat_flags),
        .spr_data   (spr_data),
        .rbuf_data  (rbuf_data),
        .pal_space  (pal_space),
        .latch_q    (io_latch),
        .latch_nxt  (merged)
    );

    // Accept an access only inside the window; a write loads the raw byte
    always_comb begin
        acc      = bus_req && hit;
        load_val = bus_we ? bus_wdata : merged;
    end

    vidreg_latch #(
        .D_W (DATA_W),
        .S_W (SEL_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (acc),
        .load_val  (load_val),
        .rd_go     (acc && !bus_we),
        .wr_go     (acc && bus_we),
        .wr_go_sel (sel),
        .latch_q   (io_latch),
        .rd_valid  (rd_valid),
        .wr_stb    (wr_stb),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/vidreg_latch_chk.sv
// Checker: temporal properties of the I/O latch, attached by bind.
// Decodes the window on its own from the address bits.
module vidreg_latch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_req,
    input logic        bus_we,
    input logic [15:0] bus_addr,
    input logic [7:0]  bus_wdata,
    input logic [2:0]  stat_flags,
    input logic        pal_space,
    input logic [7:0]  io_latch,
    input logic        rd_valid,
    input logic        wr_stb,
    input logic [2:0]  wr_sel,
    input logic [7:0]  wr_data
);
    logic in_win;
    logic wr_acc;
    logic rd_acc;
    logic rd_wo;

    // Independent window decode and access classification
    always_comb begin
        in_win = (bus_addr[15:13] == 3'b001);
        wr_acc = bus_req && in_win && bus_we;
        rd_acc = bus_req && in_win && !bus_we;
        rd_wo  = rd_acc && (bus_addr[2:0] inside {3'd0, 3'd1, 3'd3, 3'd5, 3'd6});
    end

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> io_latch == $past(bus_wdata));

    // R3
    wr_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> ##1 (wr_stb && wr_sel == $past(bus_addr[2:0], 2)
                        && wr_data == $past(bus_wdata, 2)));

    // R4
    wo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |=> $stable(io_latch));

    // R5
    stat_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr[2:0] == 3'd2) |=>
            (io_latch[7:5] == $past(stat_flags) && io_latch[4:0] == $past(io_latch[4:0])));

    // R8
    pal_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && bus_addr[2:0] == 3'd7 && pal_space) |=>
            io_latch[7:6] == $past(io_latch[7:6]));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && in_win) |=> ($stable(io_latch) && !rd_valid));

    // R11
    rdv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_acc));
endmodule

bind vidreg_latch_top vidreg_latch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .stat_flags (stat_flags),
    .pal_space  (pal_space),
    .io_latch   (io_latch),
    .rd_valid   (rd_valid),
    .wr_stb     (wr_stb),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data)
);

// File: tb/vidreg_latch_top_bench.sv
// Scoreboard bench: tasks queue expected reads and forwarded writes,
// a monitor pops and compares them at falling edges.
module vidreg_latch_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [2:0]  stat_flags = '0;
    logic [7:0]  spr_data = '0;
    logic [7:0]  rbuf_data = '0;
    logic        pal_space = 1'b0;
    logic [7:0]  io_latch;
    logic        rd_valid;
    logic        wr_stb;
    logic [2:0]  wr_sel;
    logic [7:0]  wr_data;

    int errors = 0;
    int checks = 0;
    logic [7:0] model = 8'h00;

    logic [7:0]  rd_q[$];
    string       rd_tag[$];
    logic [10:0] wr_q[$];
    string       wr_tag[$];

    always #2 clk = ~clk;

    vidreg_latch_top u_vidreg_latch_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .stat_flags(stat_flags),
        .spr_data(spr_data), .rbuf_data(rbuf_data), .pal_space(pal_space),
        .io_latch(io_latch), .rd_valid(rd_valid), .wr_stb(wr_stb),
        .wr_sel(wr_sel), .wr_data(wr_data)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Expected latch after a read, from the requirements
    function automatic logic [7:0] read_model(input logic [2:0] ofs, input logic [7:0] cur);
        case (ofs)
            3'd2:    return {stat_flags, cur[4:0]};
            3'd4:    return spr_data;
            3'd7:    return pal_space ? {cur[7:6], rbuf_data[5:0]} : rbuf_data;
            default: return cur;
        endcase
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        if (a[15:13] == 3'b001) begin
            model = d;
            rd_q.push_back(d);  // latch visible via next R2 check below
            rd_tag.push_back(tag);
            wr_q.push_back({a[2:0], d});
            wr_tag.push_back("R3");
        end
        @(negedge clk);
        bus_req = 1'b0;
        if (a[15:13] == 3'b001) begin
            check(tag, io_latch, rd_q.pop_back());
            void'(rd_tag.pop_back());
        end else begin
            check("R10 latch", io_latch, model);
            check("R10 rd_valid", rd_valid, 1'b0);
        end
    endtask

    task automatic do_read(input logic [15:0] a, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        if (a[15:13] == 3'b001) begin
            model = read_model(a[2:0], model);
            rd_q.push_back(model);
            rd_tag.push_back(tag);
        end
        @(negedge clk);
        bus_req = 1'b0;
        if (a[15:13] != 3'b001) begin
            check("R10 latch", io_latch, model);
            check("R10 rd_valid", rd_valid, 1'b0);
        end
    endtask

    // Monitor: compare due results at each falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    check("R11 unexpected rd_valid", 1, 0);
                end else begin
                    check(rd_tag.pop_front(), io_latch, rd_q.pop_front());
                end
            end
            if (wr_stb) begin
                if (wr_q.size() == 0) begin
                    check("R3 unexpected wr_stb", 1, 0);
                end else begin
                    check(wr_tag.pop_front(), {wr_sel, wr_data}, wr_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 latch", io_latch, 8'h00);
        check("R1 strobes", {rd_valid, wr_stb}, 2'b00);

        do_write(16'h2005, 8'hFF, "R2");
        stat_flags = 3'b101;
        do_read(16'h2002, "R5 status");          // BF
        do_read(16'h2001, "R4 write-only");      // BF
        do_write(16'h3F06, 8'h3C, "R9 write");
        do_read(16'h2000, "R4 offset0");         // 3C
        spr_data = 8'hA5;
        do_read(16'h2004, "R6 sprite");          // A5
        rbuf_data = 8'h5A; pal_space = 1'b0;
        do_read(16'h2007, "R7 data");            // 5A
        do_write(16'h2003, 8'hC0, "R2");
        rbuf_data = 8'h12; pal_space = 1'b1;
        do_read(16'h2007, "R8 palette");         // D2
        stat_flags = 3'b010;
        do_read(16'h2102, "R9 mirror");          // 52
        do_read(16'h3F02, "R9 mirror top");
        do_write(16'h4005, 8'h77, "R10");
        do_read(16'h1FFF, "R10");
        do_read(16'h3FFB, "R4 mirror");
        repeat (3) @(negedge clk);
        check("R10 idle", io_latch, model);

        for (int i = 0; i < 16; i++) begin
            stat_flags = 3'(i * 3);
            spr_data   = 8'(i * 37 + 5);
            rbuf_data  = 8'(i * 91 + 17);
            pal_space  = i[1];
            if (i[2]) do_write(16'h2000 + 16'(i * 264), 8'(i * 29 + 3), "R2 sweep");
            do_read(16'h2000 + 16'(i * 520 + i), "R9 sweep");
        end

        repeat (4) @(negedge clk);
        check("R3 queue drained", wr_q.size(), 0);
        check("R11 queue drained", rd_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule